// File: doc/BRIEF.md
# Fractional Clock Divider Control Register Bank

This block holds one control word for a group of clock dividers. The word is split into equal byte-wide slots, four by default. Each slot carries a 6-bit fractional divide value and a gate bit. When the gate bit is 1, that slot's clock output is held off. Every slot drives its divide value and its gate state straight out to the clock generator.

Software reaches the word through one small bus port with a word address, a write strobe, write data and read data. The port decodes four word addresses, and all four act on the same storage. The first address loads the whole word. The other three are atomic aliases: one sets bits, one clears bits and one flips bits, wherever the write data holds a 1. With these aliases, a driver can change one slot without reading the word first.

Top module: `divbank_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, every slot has its gate bit at 1 and its divide value at 18, so the full word reads 0x92929292.
- R2: A write to word address 0 (bus_addr[3:2] = 0) replaces every writable bit with the matching write-data bit.
- R3: A write to word address 1 (bus_addr[3:2] = 1) sets each writable bit where the write data is 1. All other bits keep their value.
- R4: A write to word address 2 (bus_addr[3:2] = 2) clears each writable bit where the write data is 1. All other bits keep their value.
- R5: A write to word address 3 (bus_addr[3:2] = 3) inverts each writable bit where the write data is 1. All other bits keep their value.
- R6: Bit 6 of every slot (bits 6, 14, 22 and 30) is reserved. It always reads 0, and no write at any address changes it.
- R7: bus_rdata always shows the current word, whatever the address. A write shows up in bus_rdata on the cycle after the clock edge that takes it.
- R8: Slot n sits in bits [8n+7:8n] of the word. div_val[6n+5:6n] equals word bits [8n+5:8n], and gate_off[n] equals word bit 8n+7.
- R9: While bus_we is 0, the word does not change, whatever the address or data.
- R10: The decode ignores bus_addr[1:0]. A write to an address with nonzero low bits acts the same as a write to the aligned address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address; bits [3:2] choose load, set, clear or toggle |
| bus_wdata | input | 32 | Write data, or the bit mask for an alias write |
| bus_rdata | output | 32 | Current control word |
| div_val | output | 24 | Divide values of all slots, slot n at [6n+5:6n] |
| gate_off | output | 4 | Gate state per slot; 1 holds that slot's clock off |

## Verification
The bench walks a chain of writes in which each result depends on the one before. A design that mixes up the set and clear aliases, or that toggles the whole word instead of only the masked bits, therefore goes wrong at once and stays wrong. An all-ones toggle and an all-ones load both hit the reserved bits. A design that stores those bits would read back a 1 at bit 6 of a slot. The bench also writes with nonzero low address bits, to catch a decode on the full address. It puts data on the bus with the strobe low, to catch a design that writes without the strobe. Two toggles back to back must restore the word, and a reset partway through the run must bring every slot back to gated with a divide value of 18.

// File: rtl/divbank_pkg.sv
package divbank_pkg;

    localparam int SLOT_W    = 8;
    localparam int DIV_W     = 6;
    localparam int GATE_POS  = 7;
    localparam int DIV_RESET = 18;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_TOG  = 2'd3
    } bank_op_e;

    typedef struct packed {
        logic             gate;
        logic [DIV_W-1:0] div;
    } slot_t;

    function automatic slot_t slot_from_byte(input logic [SLOT_W-1:0] b);
        slot_t s;
        s.gate = b[GATE_POS];
        s.div  = b[DIV_W-1:0];
        return s;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_to_byte(input slot_t s);
        logic [SLOT_W-1:0] b;
        b = '0;
        b[GATE_POS]    = s.gate;
        b[DIV_W-1:0]   = s.div;
        return b;
    endfunction

    function automatic slot_t slot_next(input bank_op_e op, input slot_t cur, input slot_t arg);
        slot_t n;
        case (op)
            OP_LOAD: n = arg;
            OP_SET:  n = slot_t'(cur | arg);
            OP_CLR:  n = slot_t'(cur & ~arg);
            default: n = slot_t'(cur ^ arg);
        endcase
        return n;
    endfunction

    function automatic slot_t slot_reset();
        slot_t s;
        s.gate = 1'b1;
        s.div  = DIV_W'(DIV_RESET);
        return s;
    endfunction

endpackage

// File: rtl/divbank_decode.sv
module divbank_decode
    import divbank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_op_e          op
);
    localparam int SEL_LO = 2;

    always_comb begin
        op = bank_op_e'(addr[SEL_LO +: 2]);
    end

endmodule

// File: rtl/divbank_slot.sv
module divbank_slot
    import divbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  bank_op_e op,
    input  slot_t    arg,
    output slot_t    q
);
    slot_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= slot_reset();
        end else if (wr_en) begin
            q_r <= slot_next(op, q_r, arg);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/divbank_ctrl.sv
module divbank_ctrl
    import divbank_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [SLOTS*SLOT_W-1:0]  bus_wdata,
    output logic [SLOTS*SLOT_W-1:0]  bus_rdata,
    output logic [SLOTS*DIV_W-1:0]   div_val,
    output logic [SLOTS-1:0]         gate_off
);
    bank_op_e op;

    divbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .op   (op)
    );

    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
        slot_t cur;

        divbank_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_we),
            .op    (op),
            .arg   (slot_from_byte(bus_wdata[n*SLOT_W +: SLOT_W])),
            .q     (cur)
        );

        assign bus_rdata[n*SLOT_W +: SLOT_W] = slot_to_byte(cur);
        assign div_val[n*DIV_W +: DIV_W]     = cur.div;
        assign gate_off[n]                   = cur.gate;
    end

endmodule

// File: rtl/divbank_ctrl_chk.sv
module divbank_ctrl_chk
    import divbank_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [SLOTS*SLOT_W-1:0] bus_wdata,
    input logic [SLOTS*SLOT_W-1:0] bus_rdata,
    input logic [SLOTS*DIV_W-1:0]  div_val,
    input logic [SLOTS-1:0]        gate_off
);
    localparam int W = SLOTS * SLOT_W;

    function automatic logic [W-1:0] make_mask();
        logic [W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOTS; i++) begin
            m[i*SLOT_W + GATE_POS] = 1'b1;
            m[i*SLOT_W +: DIV_W]   = '1;
        end
        return m;
    endfunction

    function automatic logic [W-1:0] make_reset();
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < SLOTS; i++) begin
            r[i*SLOT_W + GATE_POS] = 1'b1;
            r[i*SLOT_W +: DIV_W]   = DIV_W'(DIV_RESET);
        end
        return r;
    endfunction

    localparam logic [W-1:0] WMASK      = make_mask();
    localparam logic [W-1:0] RESET_WORD = make_reset();

    logic [1:0] sel;
    assign sel = bus_addr[3:2];

    assert_reset_word_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> bus_rdata == RESET_WORD);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == 2'd0) |=> bus_rdata == $past(bus_wdata & WMASK));

    assert_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == 2'd1) |=> bus_rdata == $past(bus_rdata | (bus_wdata & WMASK)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == 2'd2) |=> bus_rdata == $past(bus_rdata & ~bus_wdata));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == 2'd3) |=> bus_rdata == $past(bus_rdata ^ (bus_wdata & WMASK)));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~WMASK) == '0);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(bus_rdata));

    for (genvar n = 0; n < SLOTS; n++) begin : g_map
        assert_slot_map_R8: assert property (@(posedge clk) disable iff (rst)
            div_val[n*DIV_W +: DIV_W] == bus_rdata[n*SLOT_W +: DIV_W]
            && gate_off[n] == bus_rdata[n*SLOT_W + GATE_POS]);
    end

endmodule

bind divbank_ctrl divbank_ctrl_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .div_val   (div_val),
    .gate_off  (gate_off)
);

// File: tb/sim_divbank_ctrl.sv
module sim_divbank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] div_val;
    logic [3:0]  gate_off;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    divbank_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_val   (div_val),
        .gate_off  (gate_off)
    );

    // {addr, wdata, expected word}
    localparam logic [67:0] VEC [8] = '{
        {4'h0, 32'h12345678, 32'h12341638},  // R2 R6
        {4'h4, 32'h80004040, 32'h92341638},  // R3 R6
        {4'h8, 32'h000000FF, 32'h92341600},  // R4
        {4'hC, 32'h0F0F0F0F, 32'h9D3B190F},  // R5
        {4'hC, 32'hFFFFFFFF, 32'h2284A6B0},  // R5 R6
        {4'h5, 32'h00000001, 32'h2284A6B1},  // R10 R3
        {4'hB, 32'hFFFFFFFF, 32'h00000000},  // R10 R4
        {4'h4, 32'h00800000, 32'h00800000}   // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: slot n at [8n+7:8n]; divide in [5:0], gate at bit 7
    task automatic check_outputs(input string req, input logic [31:0] word);
        logic [23:0] dv;
        logic [3:0]  g;
        for (int n = 0; n < 4; n++) begin
            dv[n*6 +: 6] = word[n*8 +: 6];
            g[n]         = word[n*8 + 7];
        end
        check({req, " R8 div"}, {8'h0, div_val}, {8'h0, dv});
        check({req, " R8 gate"}, {28'h0, gate_off}, {28'h0, g});
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset word", bus_rdata, 32'h92929292);
        check_outputs("R1", 32'h92929292);

        foreach (VEC[i]) begin
            bus_write(VEC[i][67:64], VEC[i][63:32]);
            check($sformatf("R2-chain vec%0d R7", i), bus_rdata, VEC[i][31:0]);
            check_outputs("vec", VEC[i][31:0]);
        end

        // R9: bus activity without strobe changes nothing
        @(negedge clk);
        bus_addr  = 4'h0;
        bus_wdata = 32'hFFFFFFFF;
        bus_we    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 no strobe", bus_rdata, 32'h00800000);

        // R7: alias addresses read the same word
        bus_addr = 4'hC;
        #1;
        check("R7 read at toggle alias", bus_rdata, 32'h00800000);
        bus_addr = 4'h8;
        #1;
        check("R7 read at clear alias", bus_rdata, 32'h00800000);

        // R5: back-to-back toggles restore the word
        @(negedge clk);
        bus_addr  = 4'hC;
        bus_wdata = 32'h3F3F0000;
        bus_we    = 1'b1;
        @(negedge clk);
        check("R5 first toggle", bus_rdata, 32'h3FBF0000);
        @(negedge clk);
        bus_we = 1'b0;
        check("R5 second toggle", bus_rdata, 32'h00800000);

        // R6: full load of ones leaves reserved bits at 0
        bus_write(4'h0, 32'hFFFFFFFF);
        check("R6 reserved after load", bus_rdata, 32'hBFBFBFBF);
        check_outputs("R6", 32'hBFBFBFBF);

        // R1: reset partway through
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", bus_rdata, 32'h92929292);

        done = 1;
        finish_run();
    end

endmodule